// File: doc/BRIEF.md
# Floating-Point Status Register Updater

This block produces the next value of a 32-bit floating-point status register once an operation has finished. It takes the status word as it stood, the sign and class of the result, and the trap-enable control word. It returns the updated status word and a one-cycle trap request. The arithmetic is done elsewhere; this block only rewrites flags.

The update runs in a fixed order, and later steps read what earlier steps wrote. The condition-code nibble is cleared and rebuilt from the result. A signalling-NaN result also raises its exception flag. Sticky accrued bits are then OR-ed in from the exception byte as it now stands. Last, the exception byte is masked with the control word to decide whether to trap. The status result is registered, and it holds its value between updates.

Top module: `fpsu_update`

## Requirements
- R1: While `rst` is high, at the next clock edge `stat_o` becomes 0 and `trap_o` becomes 0.
- R2: On an update, bits 27:24 of the status are cleared, and then bit 27 (negative) is set when `res_sign_i` is 1.
- R3: Class codes on `res_cls_i` set one flag each. Code 0 is a signalling NaN and sets bit 24. Code 1 is a quiet NaN and sets bit 24. Code 2 is zero and sets bit 26. Code 4 is infinity and sets bit 25. Code 3 is an ordinary number, and codes 5 to 7 are treated the same way; none of these four sets a class flag.
- R4: A signalling-NaN result (code 0) also sets bit 14 of the exception byte. No other class changes the exception byte.
- R5: Accrued invalid (bit 7) is set when any of bits 15, 14 or 13 of the updated status is set.
- R6: Accrued overflow (bit 6) is set when bit 12 is set. Accrued divide-by-zero (bit 4) is set when bit 10 is set.
- R7: Accrued underflow (bit 5) is set only when bit 11 and bit 9 are both set.
- R8: Accrued inexact (bit 3) is set when any of bits 9, 8 or 12 is set.
- R9: Accrued bits 7:3 that were already 1 in `stat_i` stay 1. Bits 31:28, 23:16 and 2:0 pass through unchanged.
- R10: `trap_o` is 1 exactly when the updated status, AND-ed with `ctrl_i` and with mask 0x0000FF00, is nonzero.
- R11: Results appear one clock after `upd_i`. When `upd_i` is low, `stat_o` holds its value and `trap_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_i | input | 1 | Update strobe |
| stat_i | input | 32 | Status word before the update |
| ctrl_i | input | 32 | Trap-enable control word |
| res_sign_i | input | 1 | Result sign, 1 for negative |
| res_cls_i | input | 3 | Result class code |
| stat_o | output | 32 | Registered updated status |
| trap_o | output | 1 | Registered trap request |

## Verification
The properties assume that the inputs are stable and known at each rising edge where `upd_i` is sampled. They also assume that a property is evaluated only in the cycle right after an update, so `$past` of the inputs refers to that update. The stimulus changes inputs only on falling edges. It drives every class code, including the unused codes 5 to 7, under the sweeps of the exception byte and the control word. It inserts idle cycles that leave `upd_i` low but change the other inputs, which exercises the hold rule.

// File: rtl/fpsu_pkg.sv
package fpsu_pkg;
  // condition-code nibble positions
  localparam int CC_NEG  = 27;
  localparam int CC_ZERO = 26;
  localparam int CC_INF  = 25;
  localparam int CC_NAN  = 24;
  localparam int CC_LO   = 24;
  localparam int CC_W    = 4;
  // exception byte positions
  localparam int EX_BSUN  = 15;
  localparam int EX_SNAN  = 14;
  localparam int EX_OPERR = 13;
  localparam int EX_OVFL  = 12;
  localparam int EX_UNFL  = 11;
  localparam int EX_DZ    = 10;
  localparam int EX_INEX2 = 9;
  localparam int EX_INEX1 = 8;
  localparam int EX_LO    = 8;
  localparam int EX_W     = 8;
  // accrued positions
  localparam int AC_IOP  = 7;
  localparam int AC_OVFL = 6;
  localparam int AC_UNFL = 5;
  localparam int AC_DZ   = 4;
  localparam int AC_INEX = 3;

  typedef enum logic [2:0] {
    CLS_SNAN = 3'd0,
    CLS_QNAN = 3'd1,
    CLS_ZERO = 3'd2,
    CLS_NUM  = 3'd3,
    CLS_INF  = 3'd4
  } res_cls_e;
endpackage

// File: rtl/fpsu_ccode.sv
module fpsu_ccode
  import fpsu_pkg::*;
#(
  parameter int STAT_W = 32,
  parameter int CLS_W  = 3
) (
  input  logic [STAT_W-1:0] stat_in,
  input  logic              sign_in,
  input  logic [CLS_W-1:0]  cls_in,
  output logic [STAT_W-1:0] stat_out
);
  logic [CC_W-1:0] cc;
  logic            snan_hit;

  always_comb begin
    cc       = '0;
    snan_hit = 1'b0;
    cc[CC_NEG-CC_LO] = sign_in;
    case (cls_in)
      CLS_SNAN: begin
        cc[CC_NAN-CC_LO] = 1'b1;
        snan_hit         = 1'b1;
      end
      CLS_QNAN: cc[CC_NAN-CC_LO]  = 1'b1;
      CLS_ZERO: cc[CC_ZERO-CC_LO] = 1'b1;
      CLS_INF:  cc[CC_INF-CC_LO]  = 1'b1;
      default:  ;
    endcase
  end

  always_comb begin
    stat_out = stat_in;
    stat_out[CC_LO +: CC_W] = cc;
    stat_out[EX_SNAN] = stat_in[EX_SNAN] | snan_hit;
  end
endmodule

// File: rtl/fpsu_accrue.sv
module fpsu_accrue
  import fpsu_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic [STAT_W-1:0] stat_in,
  output logic [STAT_W-1:0] stat_out
);
  logic [EX_W-1:0] ex;
  assign ex = stat_in[EX_LO +: EX_W];

  always_comb begin
    stat_out = stat_in;
    if (ex[EX_BSUN-EX_LO] | ex[EX_SNAN-EX_LO] | ex[EX_OPERR-EX_LO])
      stat_out[AC_IOP] = 1'b1;
    if (ex[EX_OVFL-EX_LO])
      stat_out[AC_OVFL] = 1'b1;
    if (ex[EX_UNFL-EX_LO] & ex[EX_INEX2-EX_LO])
      stat_out[AC_UNFL] = 1'b1;
    if (ex[EX_DZ-EX_LO])
      stat_out[AC_DZ] = 1'b1;
    if (ex[EX_INEX1-EX_LO] | ex[EX_INEX2-EX_LO] | ex[EX_OVFL-EX_LO])
      stat_out[AC_INEX] = 1'b1;
  end
endmodule

// File: rtl/fpsu_trap.sv
module fpsu_trap
  import fpsu_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic [STAT_W-1:0] stat_in,
  input  logic [STAT_W-1:0] ctrl_in,
  output logic              trap_out
);
  localparam logic [STAT_W-1:0] EX_MASK = {{(STAT_W-EX_W){1'b0}}, {EX_W{1'b1}}} << EX_LO;
  assign trap_out = |(stat_in & ctrl_in & EX_MASK);
endmodule

// File: rtl/fpsu_update.sv
module fpsu_update
  import fpsu_pkg::*;
#(
  parameter int STAT_W = 32,
  parameter int CLS_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [STAT_W-1:0] ctrl_i,
  input  logic              res_sign_i,
  input  logic [CLS_W-1:0]  res_cls_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              trap_o
);
  logic [STAT_W-1:0] stat_cc;
  logic [STAT_W-1:0] stat_acc;
  logic              trap_d;

  fpsu_ccode #(.STAT_W(STAT_W), .CLS_W(CLS_W)) u_ccode (
    .stat_in (stat_i),
    .sign_in (res_sign_i),
    .cls_in  (res_cls_i),
    .stat_out(stat_cc)
  );

  fpsu_accrue #(.STAT_W(STAT_W)) u_accrue (
    .stat_in (stat_cc),
    .stat_out(stat_acc)
  );

  fpsu_trap #(.STAT_W(STAT_W)) u_trap (
    .stat_in (stat_acc),
    .ctrl_in (ctrl_i),
    .trap_out(trap_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_o <= '0;
      trap_o <= 1'b0;
    end else begin
      trap_o <= upd_i & trap_d;
      if (upd_i)
        stat_o <= stat_acc;
    end
  end
endmodule

// File: rtl/fpsu_update_chk.sv
module fpsu_update_chk
  import fpsu_pkg::*;
#(
  parameter int STAT_W = 32,
  parameter int CLS_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              upd_i,
  input logic [STAT_W-1:0] stat_i,
  input logic [STAT_W-1:0] ctrl_i,
  input logic              res_sign_i,
  input logic [CLS_W-1:0]  res_cls_i,
  input logic [STAT_W-1:0] stat_o,
  input logic              trap_o
);
  localparam logic [STAT_W-1:0] EXM = 32'h0000_FF00;

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (stat_o == '0) && !trap_o);

  assert_neg_follows_sign_R2: assert property (@(posedge clk) disable iff (rst)
    upd_i |=> stat_o[CC_NEG] == $past(res_sign_i));

  assert_snan_flags_R4: assert property (@(posedge clk) disable iff (rst)
    (upd_i && res_cls_i == CLS_SNAN) |=> stat_o[EX_SNAN] && stat_o[CC_NAN] && stat_o[AC_IOP]);

  assert_unfl_pair_R7: assert property (@(posedge clk) disable iff (rst)
    upd_i |=> stat_o[AC_UNFL] == ($past(stat_i[AC_UNFL]) | (stat_o[EX_UNFL] & stat_o[EX_INEX2])));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    upd_i |=> ((stat_o[7:3] & $past(stat_i[7:3])) == $past(stat_i[7:3])));

  assert_trap_mask_R10: assert property (@(posedge clk) disable iff (rst)
    upd_i |=> trap_o == (|(stat_o & $past(ctrl_i) & EXM)));

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !upd_i |=> $stable(stat_o) && !trap_o);
endmodule

bind fpsu_update fpsu_update_chk #(.STAT_W(STAT_W), .CLS_W(CLS_W)) u_chk (
  .clk(clk), .rst(rst), .upd_i(upd_i), .stat_i(stat_i), .ctrl_i(ctrl_i),
  .res_sign_i(res_sign_i), .res_cls_i(res_cls_i), .stat_o(stat_o), .trap_o(trap_o)
);

// File: tb/fpsu_update_tb.sv
module fpsu_update_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_i = 1'b0;
  logic [31:0] stat_i = '0;
  logic [31:0] ctrl_i = '0;
  logic        res_sign_i = 1'b0;
  logic [2:0]  res_cls_i = '0;
  logic [31:0] stat_o;
  logic        trap_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] exp_stat = '0;
  logic        exp_trap = 1'b0;

  always #2.5 clk = ~clk;

  fpsu_update dut_i (
    .clk(clk), .rst(rst), .upd_i(upd_i), .stat_i(stat_i), .ctrl_i(ctrl_i),
    .res_sign_i(res_sign_i), .res_cls_i(res_cls_i), .stat_o(stat_o), .trap_o(trap_o)
  );

  // behavioural reference, written from the requirement list
  function automatic void model(input logic [31:0] s, input logic [31:0] c,
                                input logic sg, input logic [2:0] cl,
                                output logic [31:0] ns, output logic nt);
    int k;
    ns = s;
    for (k = 24; k < 28; k++) ns[k] = 1'b0;          // R2
    if (sg) ns[27] = 1'b1;
    if (cl == 3'd0) begin ns[24] = 1'b1; ns[14] = 1'b1; end // R3 R4
    else if (cl == 3'd1) ns[24] = 1'b1;
    else if (cl == 3'd2) ns[26] = 1'b1;
    else if (cl == 3'd4) ns[25] = 1'b1;
    if (ns[15] || ns[14] || ns[13]) ns[7] = 1'b1;    // R5
    if (ns[12]) ns[6] = 1'b1;                        // R6
    if (ns[10]) ns[4] = 1'b1;
    if (ns[11] && ns[9]) ns[5] = 1'b1;               // R7
    if (ns[9] || ns[8] || ns[12]) ns[3] = 1'b1;      // R8
    nt = 1'b0;
    for (k = 8; k < 16; k++) if (ns[k] && c[k]) nt = 1'b1; // R10
  endfunction

  task automatic check(input string tag);
    n_chk++;
    if (stat_o !== exp_stat || trap_o !== exp_trap) begin
      n_fail++;
      $display("FAIL %s: stat=%h trap=%b expected stat=%h trap=%b",
               tag, stat_o, trap_o, exp_stat, exp_trap);
    end
  endtask

  // drive on falling edge, check one cycle later (R11 latency)
  task automatic step(input string tag, input logic v, input logic [31:0] s,
                      input logic [31:0] c, input logic sg, input logic [2:0] cl);
    logic [31:0] ns;
    logic nt;
    upd_i = v; stat_i = s; ctrl_i = c; res_sign_i = sg; res_cls_i = cl;
    if (v) begin
      model(s, c, sg, cl, ns, nt);
      exp_stat = ns;
      exp_trap = nt;
    end else begin
      exp_trap = 1'b0;
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    stat_i = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    exp_stat = '0; exp_trap = 1'b0;
    check("R1");
    rst = 1'b0;

    // R2 sign and cc clear
    step("R2", 1, 32'h0F00_0000, 32'h0, 1, 3'd3);
    step("R2", 1, 32'h0F00_0000, 32'h0, 0, 3'd3);
    // R3 every class code, both signs
    for (int cl = 0; cl < 8; cl++) begin
      step("R3", 1, 32'h0A00_0000, 32'h0, cl[0], cl[2:0]);
    end
    // R4 snan sets exception, others do not
    step("R4", 1, 32'h0, 32'hFFFF_FFFF, 0, 3'd0);
    step("R4", 1, 32'h0, 32'hFFFF_FFFF, 0, 3'd1);
    // R5..R8 walk each exception bit and pairs
    for (int b = 8; b < 16; b++) begin
      step("R5", 1, 32'h1 << b, 32'h0, 0, 3'd3);
    end
    step("R6", 1, 32'h0000_1400, 32'h0, 0, 3'd2);
    step("R7", 1, 32'h0000_0800, 32'h0, 0, 3'd3);
    step("R7", 1, 32'h0000_0A00, 32'h0, 0, 3'd3);
    step("R8", 1, 32'h0000_0100, 32'h0, 1, 3'd4);
    // R9 sticky accrued and passthrough
    step("R9", 1, 32'hF0A5_00FF, 32'h0, 0, 3'd3);
    step("R9", 1, 32'h5A5A_00F8, 32'h0, 1, 3'd2);
    // R10 trap mask
    step("R10", 1, 32'h0000_1000, 32'h0000_1000, 0, 3'd3);
    step("R10", 1, 32'h0000_1000, 32'hFFFF_EFFF, 0, 3'd3);
    step("R10", 1, 32'h0000_0000, 32'h0000_4000, 0, 3'd0);
    step("R10", 1, 32'h0000_00FF, 32'hFFFF_00FF, 0, 3'd3);
    // R11 hold when idle
    step("R11", 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 3'd0);
    step("R11", 0, 32'h1234_5678, 32'hFFFF_FFFF, 0, 3'd2);
    // mixed sweep
    for (int i = 0; i < 64; i++) begin
      logic [31:0] s;
      logic [31:0] c;
      s = (i * 32'h9E37_79B9) ^ (i << 11);
      c = (i * 32'h85EB_CA6B);
      step("R10", (i % 5) != 0, s, c, i[1], i[4:2]);
    end
    @(negedge clk);
    finish_run();
  end
endmodule